// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands of an in-order five-stage pipeline, where the execute stage should take its value from. Operand A is named by the source field `rs` of the instruction in execute, operand B by its `rt` field. A result that is not yet in the register file can be taken from the register after execute (one instruction older) or from the register after memory (two instructions older). The block compares the source register numbers with the destination numbers and write enables held in those two registers and drives a 2-bit select for each operand mux.

The decision itself is purely combinational. For testing, a small wrapper registers the pipeline-register fields on each clock edge, so that the selects reflect the fields captured at the most recent edge. Register 0 is hard-wired to zero, so a destination of 0 never causes a bypass. When both older instructions write the register an operand needs, the one that left execute most recently wins, because it holds the newer value. A result three instructions older needs no bypass: the register file returns a value written in the same cycle as it is read.

Top module: `operand_bypass_top`

## Requirements
- R1: While reset is high, and in the cycle after reset is released with no new fields applied, both selects are 2'b00 (register file).
- R2: An operand's select is 2'b10 (post-execute result) when the post-execute write enable is 1, its destination is nonzero and its destination equals that operand's source number.
- R3: An operand's select is 2'b01 (post-memory result) when the post-memory write enable is 1, its destination is nonzero, it equals the operand's source number and the rule of R2 does not hold for that operand.
- R4: When the rules of R2 and R3 both hold for one operand, its select is 2'b10.
- R5: A destination of register 0 never produces a nonzero select, even with its write enable set and a matching source of 0.
- R6: A stage whose write enable is 0 never produces a bypass, whatever its destination number.
- R7: Operand A is judged only from `rs` and operand B only from `rt`; the two selects are independent and may differ in the same cycle.
- R8: Neither select ever takes the value 2'b11.
- R9: Input fields are captured on the rising clock edge; the selects change only after that edge and reflect the most recently captured fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idex_rs_i | input | 5 | Source register number for operand A |
| idex_rt_i | input | 5 | Source register number for operand B |
| exm_we_i | input | 1 | Write enable of the instruction after execute |
| exm_rd_i | input | 5 | Destination of the instruction after execute |
| mwb_we_i | input | 1 | Write enable of the instruction after memory |
| mwb_rd_i | input | 5 | Destination of the instruction after memory |
| sel_a_o | output | 2 | Operand A select: 00 register file, 01 post-memory, 10 post-execute |
| sel_b_o | output | 2 | Operand B select, same encoding |

## Verification
The two bypass sources can both match one operand in the same cycle, which is where the priority rule matters. The bench provokes this by giving both older stages the same nonzero destination, equal to `rs` or `rt`, with both write enables set, and judges it correct only if that operand's select is 2'b10. It also loads one stage matching `rs` and the other matching `rt` in the same cycle to confirm that the two operands are decided independently.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int REG_AW  = 5;
    localparam int NUM_OPS = 2;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_MWB = 2'b01,
        SEL_EXM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic              we;
        logic [REG_AW-1:0] rd;
    } dest_t;

    function automatic logic dest_hits(input dest_t d, input logic [REG_AW-1:0] src);
        return d.we && (d.rd != '0) && (d.rd == src);
    endfunction

    function automatic fwd_sel_e pick_source(input logic [REG_AW-1:0] src,
                                             input dest_t exm,
                                             input dest_t mwb);
        if (dest_hits(exm, src))
            return SEL_EXM;
        else if (dest_hits(mwb, src))
            return SEL_MWB;
        else
            return SEL_RF;
    endfunction

endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic [AW-1:0] src,
    input  dest_t         exm,
    input  dest_t         mwb,
    output fwd_sel_e      sel
);

    always_comb begin
        sel = pick_source(src, exm, mwb);
    end

endmodule

// File: rtl/fwd_stage_regs.sv
module fwd_stage_regs
    import fwd_pkg::*;
#(
    parameter int AW   = REG_AW,
    parameter int NOPS = NUM_OPS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NOPS-1:0][AW-1:0]  src_d,
    input  dest_t                    exm_d,
    input  dest_t                    mwb_d,
    output logic [NOPS-1:0][AW-1:0]  src_q,
    output dest_t                    exm_q,
    output dest_t                    mwb_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            exm_q <= '0;
            mwb_q <= '0;
        end else begin
            src_q <= src_d;
            exm_q <= exm_d;
            mwb_q <= mwb_d;
        end
    end

endmodule

// File: rtl/operand_bypass_top.sv
module operand_bypass_top
    import fwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] idex_rs_i,
    input  logic [REG_AW-1:0] idex_rt_i,
    input  logic              exm_we_i,
    input  logic [REG_AW-1:0] exm_rd_i,
    input  logic              mwb_we_i,
    input  logic [REG_AW-1:0] mwb_rd_i,
    output logic [1:0]        sel_a_o,
    output logic [1:0]        sel_b_o
);

    localparam int OP_A = 0;
    localparam int OP_B = 1;

    logic [NUM_OPS-1:0][REG_AW-1:0] src_d, src_q;
    dest_t                          exm_d, exm_q, mwb_d, mwb_q;
    fwd_sel_e                       sel_v [NUM_OPS];

    assign src_d[OP_A] = idex_rs_i;
    assign src_d[OP_B] = idex_rt_i;
    assign exm_d       = '{we: exm_we_i, rd: exm_rd_i};
    assign mwb_d       = '{we: mwb_we_i, rd: mwb_rd_i};

    fwd_stage_regs #(.AW(REG_AW), .NOPS(NUM_OPS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .src_d (src_d),
        .exm_d (exm_d),
        .mwb_d (mwb_d),
        .src_q (src_q),
        .exm_q (exm_q),
        .mwb_q (mwb_q)
    );

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        fwd_operand_sel #(.AW(REG_AW)) u_sel (
            .src (src_q[g]),
            .exm (exm_q),
            .mwb (mwb_q),
            .sel (sel_v[g])
        );
    end

    assign sel_a_o = sel_v[OP_A];
    assign sel_b_o = sel_v[OP_B];

    // R1: first cycle after reset shows register-file selects
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_a_o == 2'b00 && sel_b_o == 2'b00));

    // R4: a post-execute hit on rs wins regardless of the post-memory stage
    assert_exm_priority_R4: assert property (@(posedge clk) disable iff (rst)
        (exm_q.we && exm_q.rd != '0 && exm_q.rd == src_q[OP_A]) |-> (sel_a_o == 2'b10));

    // R5: zero destinations on both stages never bypass
    assert_zero_dest_R5: assert property (@(posedge clk) disable iff (rst)
        (exm_q.rd == '0 && mwb_q.rd == '0) |-> (sel_a_o == 2'b00 && sel_b_o == 2'b00));

    // R6 / R9: no write enables at the inputs means register file after the edge
    assert_no_we_next_R6: assert property (@(posedge clk) disable iff (rst)
        (!exm_we_i && !mwb_we_i) |=> (sel_a_o == 2'b00 && sel_b_o == 2'b00));

    // R8: the unused code never appears
    assert_no_code3_R8: assert property (@(posedge clk) disable iff (rst)
        (sel_a_o != 2'b11 && sel_b_o != 2'b11));

endmodule

// File: tb/tb_operand_bypass_top.sv
module tb_operand_bypass_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] rs = '0, rt = '0, exm_rd = '0, mwb_rd = '0;
    logic       exm_we = 1'b0, mwb_we = 1'b0;
    logic [1:0] sel_a, sel_b;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    operand_bypass_top dut (
        .clk       (clk),
        .rst       (rst),
        .idex_rs_i (rs),
        .idex_rt_i (rt),
        .exm_we_i  (exm_we),
        .exm_rd_i  (exm_rd),
        .mwb_we_i  (mwb_we),
        .mwb_rd_i  (mwb_rd),
        .sel_a_o   (sel_a),
        .sel_b_o   (sel_b)
    );

    task automatic check(input string req, input logic [1:0] exp_a, input logic [1:0] exp_b);
        checks++;
        if (sel_a !== exp_a || sel_b !== exp_b) begin
            failures++;
            $display("FAIL %s: sel_a=%b sel_b=%b expected sel_a=%b sel_b=%b",
                     req, sel_a, sel_b, exp_a, exp_b);
        end
        checks++;
        if (sel_a === 2'b11 || sel_b === 2'b11) begin
            failures++;
            $display("FAIL R8: sel_a=%b sel_b=%b expected no 11", sel_a, sel_b);
        end
    endtask

    // drive on the falling edge, the rising edge captures, sample at the next falling edge
    task automatic apply(input logic [4:0] a_rs, input logic [4:0] a_rt,
                         input logic a_ew, input logic [4:0] a_ed,
                         input logic a_mw, input logic [4:0] a_md);
        @(negedge clk);
        rs = a_rs; rt = a_rt;
        exm_we = a_ew; exm_rd = a_ed;
        mwb_we = a_mw; mwb_rd = a_md;
        @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 during reset", 2'b00, 2'b00);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", 2'b00, 2'b00);
    endtask

    task automatic t_no_hazard;
        apply(5'd3, 5'd4, 1'b1, 5'd7, 1'b1, 5'd9);
        check("R2 no match", 2'b00, 2'b00);
    endtask

    task automatic t_dist1;
        apply(5'd1, 5'd3, 1'b1, 5'd1, 1'b0, 5'd0);
        check("R2 distance-1 on A", 2'b10, 2'b00);
        apply(5'd2, 5'd6, 1'b1, 5'd6, 1'b0, 5'd0);
        check("R2 distance-1 on B", 2'b00, 2'b10);
    endtask

    task automatic t_dist2;
        apply(5'd8, 5'd5, 1'b0, 5'd0, 1'b1, 5'd8);
        check("R3 distance-2 on A", 2'b01, 2'b00);
        apply(5'd8, 5'd31, 1'b1, 5'd12, 1'b1, 5'd31);
        check("R3 distance-2 on B with other stage unrelated", 2'b00, 2'b01);
    endtask

    task automatic t_both;
        apply(5'd10, 5'd11, 1'b1, 5'd10, 1'b1, 5'd10);
        check("R4 both on A", 2'b10, 2'b00);
        apply(5'd14, 5'd14, 1'b1, 5'd14, 1'b1, 5'd14);
        check("R4 both on A and B", 2'b10, 2'b10);
    endtask

    task automatic t_zero;
        apply(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
        check("R5 zero destination", 2'b00, 2'b00);
        apply(5'd0, 5'd5, 1'b1, 5'd0, 1'b1, 5'd5);
        check("R5 zero on post-execute, post-memory still used", 2'b00, 2'b01);
    endtask

    task automatic t_we_off;
        apply(5'd9, 5'd9, 1'b0, 5'd9, 1'b0, 5'd9);
        check("R6 enables clear", 2'b00, 2'b00);
        apply(5'd9, 5'd2, 1'b0, 5'd9, 1'b1, 5'd9);
        check("R6 disabled post-execute yields to post-memory", 2'b01, 2'b00);
    endtask

    task automatic t_split;
        apply(5'd20, 5'd21, 1'b1, 5'd20, 1'b1, 5'd21);
        check("R7 A from post-execute, B from post-memory", 2'b10, 2'b01);
        apply(5'd21, 5'd20, 1'b1, 5'd20, 1'b1, 5'd21);
        check("R7 swapped sources", 2'b01, 2'b10);
    endtask

    task automatic t_latency;
        apply(5'd17, 5'd18, 1'b1, 5'd17, 1'b1, 5'd18);
        check("R9 setup", 2'b10, 2'b01);
        @(negedge clk);
        rs = 5'd1; rt = 5'd1; exm_we = 1'b0; mwb_we = 1'b0;
        #5;
        check("R9 old value held before edge", 2'b10, 2'b01);
        @(negedge clk);
        check("R9 new value after edge", 2'b00, 2'b00);
    endtask

    initial begin
        rst = 1'b1;
        repeat (2) @(posedge clk);
        t_reset();
        t_no_hazard();
        t_dist1();
        t_dist2();
        t_both();
        t_zero();
        t_we_off();
        t_split();
        t_latency();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule